// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits beside a small 8-bit processor core and decides which of twelve interrupt sources the core should service next. Sources are paired into six groups, and every group takes a two-bit priority level whose low bit and high bit live in two separate registers. A source asks for service only when its flag is set, its own enable is set and the global enable is set. Among the requests that qualify, the highest level wins, and a fixed polling order breaks ties.

The block presents one request at a time as `irq_req` with a 4-bit vector index. It holds both until the core pulses `ack`. On `ack` the block clears the hardware-cleared flag of the accepted source and pushes its level onto an in-service stack. A `reti` pulse pops that stack. A request reaches the core only while its level is strictly above the level now in service. One sub-source hangs off external interrupt 6. It has its own enable and flag, it needs the enable of interrupt 6 as well, and only a software write clears its flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every enable, flag and priority bit reads 0. Register addresses: 0 = source enables 7:0; 1 = bit 7 global enable, bits 3:0 source enables 11:8; 2 = flags 7:0; 3 = flags 11:8 in bits 3:0; 4 = level-low bits (bit g for group g, bits 5:0); 5 = level-high bits (bits 5:0). Reads of addresses 6 and 7 return 0. Every write replaces the stored fields, and a write to a flag register can set or clear flags.
- R2: Bit 6 of address 4 is a watchdog status bit. It is stored and read back, and it has no effect on arbitration. Bit 7 of address 4 and bits 7:6 of address 5 always read 0.
- R3: Source s belongs to group s/2. The sources in vector order are: ext0=0, serial1=1, timer0=2, ext2=3, ext1=4, ext3=5, timer1=6, ext4=7, serial0=8, ext5=9, ext6=10, sub-source=11. A group's level is {address5[g], address4[g]}, where 3 is the highest.
- R4: A source with a set flag takes part in arbitration only when its own enable and the global enable are both 1.
- R5: Among the qualifying requests, the one with the highest group level is presented.
- R6: Among qualifying requests at the same level, the lowest vector index wins. This order is group 0 first, and within a group the even index first.
- R7: `irq_req` and `irq_vec` rise on the clock edge after a qualifying flag becomes visible. They then stay unchanged until the edge that samples `ack`.
- R8: An `ack` while `irq_req` is high drops `irq_req` on that edge. The same edge clears the flag of the presented source, for sources 0 to 10.
- R9: The sub-source (index 11) needs its own enable and the enable of source 10. An `ack` does not clear its flag; only a write to address 3 does.
- R10: A request is presented only if its level is strictly higher than the top of the in-service stack, or if the stack is empty. `ack` pushes the presented level, and `reti` pops one entry.
- R11: A `src_set` bit sets its flag on the next edge. It wins over a clear by `ack` or by a register write on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of `reg_addr`, combinational |
| src_set | input | 12 | One-cycle hardware set pulses, one per source |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 4 | Index of the presented source |

## Verification
A `src_set` pulse shows in the flag registers one edge later, and `irq_req` follows one edge after that. An `ack` or `reti` acts on the edge that samples it, and register writes show on read data right after their edge. The bench keeps a behavioural model that applies the same per-edge rules. It compares `irq_req`, `irq_vec` and the read data 2 ns after every rising edge. The directed checks drive inputs on falling edges and sample just after the falling edge at the point these latencies predict. Stalls in nesting are checked over several idle cycles.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC    = 12;
  localparam int NGRP    = 6;
  localparam int LVLW    = 2;
  localparam int NEST    = 4;
  localparam int VECW    = $clog2(NSRC);
  localparam int ADDRW   = 3;
  localparam int DATAW   = 8;
  localparam int DEPW    = $clog2(NEST + 1);
  localparam int PTRW    = $clog2(NEST);
  localparam int HOST_SRC = 10;
  localparam int AUX_SRC  = 11;
  localparam int WD_BIT   = 6;

  localparam logic [ADDRW-1:0] A_EN_LO  = 3'd0;
  localparam logic [ADDRW-1:0] A_EN_HI  = 3'd1;
  localparam logic [ADDRW-1:0] A_FLG_LO = 3'd2;
  localparam logic [ADDRW-1:0] A_FLG_HI = 3'd3;
  localparam logic [ADDRW-1:0] A_LVL_LO = 3'd4;
  localparam logic [ADDRW-1:0] A_LVL_HI = 3'd5;

  typedef logic [LVLW-1:0] lvl_t;

  // group that a source belongs to: sources are paired
  function automatic int group_of(input int src);
    return src / 2;
  endfunction

  // level of a source from the two split level registers
  function automatic lvl_t level_of(input logic [NGRP-1:0] lo,
                                    input logic [NGRP-1:0] hi,
                                    input int src);
    int g;
    g = group_of(src);
    return {hi[g], lo[g]};
  endfunction

  // replace the low and/or high byte of a per-source bank
  function automatic logic [NSRC-1:0] bank_write(input logic [NSRC-1:0] cur,
                                                 input logic [DATAW-1:0] d,
                                                 input logic sel_lo,
                                                 input logic sel_hi);
    logic [NSRC-1:0] r;
    r = cur;
    for (int i = 0; i < NSRC; i++) begin
      if (i < DATAW) begin
        if (sel_lo) r[i] = d[i % DATAW];
      end else if (sel_hi) begin
        r[i] = d[i % DATAW];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ADDRW-1:0] addr,
  input  logic [DATAW-1:0] wdata,
  input  logic [NSRC-1:0]  set,
  input  logic             clr_valid,
  input  logic [VECW-1:0]  clr_idx,
  output logic [NSRC-1:0]  en,
  output logic             gen,
  output logic [NSRC-1:0]  flags,
  output logic [NGRP-1:0]  lvl_lo,
  output logic [NGRP-1:0]  lvl_hi,
  output logic [DATAW-1:0] rdata
);
  localparam logic [VECW-1:0] AUX_IDX = VECW'(AUX_SRC);

  logic [NSRC-1:0] en_q, flg_q, en_nxt, flg_nxt;
  logic [NGRP-1:0] lo_q, hi_q;
  logic            gen_q, wd_q;

  always_comb begin
    en_nxt  = bank_write(en_q, wdata, wr && addr == A_EN_LO, wr && addr == A_EN_HI);
    flg_nxt = bank_write(flg_q, wdata, wr && addr == A_FLG_LO, wr && addr == A_FLG_HI);
    if (clr_valid && clr_idx != AUX_IDX) flg_nxt[clr_idx] = 1'b0;
    flg_nxt = flg_nxt | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      flg_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      gen_q <= 1'b0;
      wd_q  <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      flg_q <= flg_nxt;
      if (wr && addr == A_EN_HI) gen_q <= wdata[DATAW-1];
      if (wr && addr == A_LVL_LO) begin
        lo_q <= wdata[NGRP-1:0];
        wd_q <= wdata[WD_BIT];
      end
      if (wr && addr == A_LVL_HI) hi_q <= wdata[NGRP-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      A_EN_LO:  rdata = en_q[DATAW-1:0];
      A_EN_HI:  rdata = {gen_q, 7'(en_q >> DATAW)};
      A_FLG_LO: rdata = flg_q[DATAW-1:0];
      A_FLG_HI: rdata = DATAW'(flg_q >> DATAW);
      A_LVL_LO: rdata = DATAW'({wd_q, lo_q});
      A_LVL_HI: rdata = DATAW'(hi_q);
      default:  rdata = '0;
    endcase
  end

  assign en     = en_q;
  assign gen    = gen_q;
  assign flags  = flg_q;
  assign lvl_lo = lo_q;
  assign lvl_hi = hi_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
(
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] en,
  input  logic            gen,
  input  logic [NGRP-1:0] lvl_lo,
  input  logic [NGRP-1:0] lvl_hi,
  output logic            win_valid,
  output logic [VECW-1:0] win_idx,
  output lvl_t            win_lvl
);
  logic [NSRC-1:0] req;

  // sub-source also needs the enable of its host interrupt
  always_comb begin
    req = flags & en & {NSRC{gen}};
    req[AUX_SRC] = req[AUX_SRC] & en[HOST_SRC];
  end

  // scan in polling order; only a strictly higher level displaces
  always_comb begin
    lvl_t lv;
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NSRC; i++) begin
      lv = level_of(lvl_lo, lvl_hi, i);
      if (req[i] && (!win_valid || lv > win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = VECW'(i);
        win_lvl   = lv;
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_prio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  lvl_t            push_lvl,
  input  logic            pop,
  output logic [DEPW-1:0] depth,
  output lvl_t            top_lvl,
  output logic            busy
);
  localparam logic [DEPW-1:0] NEST_D = DEPW'(NEST);
  localparam logic [DEPW-1:0] ONE_D  = DEPW'(1);

  lvl_t            stk_q [NEST];
  logic [DEPW-1:0] depth_q, d_after;

  assign d_after = (pop && depth_q != '0) ? depth_q - ONE_D : depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < NEST; i++) stk_q[i] <= '0;
    end else if (push && d_after < NEST_D) begin
      stk_q[PTRW'(d_after)] <= push_lvl;
      depth_q <= d_after + ONE_D;
    end else begin
      depth_q <= d_after;
    end
  end

  assign depth   = depth_q;
  assign busy    = depth_q != '0;
  assign top_lvl = busy ? stk_q[PTRW'(depth_q - ONE_D)] : '0;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [ADDRW-1:0] reg_addr,
  input  logic [DATAW-1:0] reg_wdata,
  output logic [DATAW-1:0] reg_rdata,
  input  logic [NSRC-1:0]  src_set,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VECW-1:0]  irq_vec
);
  logic [NSRC-1:0] en, flags;
  logic            gen;
  logic [NGRP-1:0] lvl_lo, lvl_hi;
  logic            win_valid;
  logic [VECW-1:0] win_idx;
  lvl_t            win_lvl;
  logic [DEPW-1:0] nest_depth;
  lvl_t            top_lvl;
  logic            nest_busy;

  logic            req_q;
  logic [VECW-1:0] vec_q;
  lvl_t            req_lvl;

  // named events for the checker
  logic take;      // core accepts the presented request
  logic forward;   // winner may be presented
  assign take    = ack && req_q;
  assign forward = win_valid && (!nest_busy || win_lvl > top_lvl);

  irq_regs u_regs (
    .clk, .rst_n,
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .set(src_set), .clr_valid(take), .clr_idx(vec_q),
    .en, .gen, .flags, .lvl_lo, .lvl_hi,
    .rdata(reg_rdata)
  );

  irq_arbiter u_arb (
    .flags, .en, .gen, .lvl_lo, .lvl_hi,
    .win_valid, .win_idx, .win_lvl
  );

  irq_nest_stack u_nest (
    .clk, .rst_n,
    .push(take), .push_lvl(req_lvl), .pop(reti),
    .depth(nest_depth), .top_lvl, .busy(nest_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      vec_q   <= '0;
      req_lvl <= '0;
    end else if (req_q) begin
      if (ack) req_q <= 1'b0;
    end else if (forward) begin
      req_q   <= 1'b1;
      vec_q   <= win_idx;
      req_lvl <= win_lvl;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [ADDRW-1:0] reg_addr,
  input logic [DATAW-1:0] reg_rdata,
  input logic [NSRC-1:0]  src_set,
  input logic             ack,
  input logic             irq_req,
  input logic [VECW-1:0]  irq_vec,
  input logic [NSRC-1:0]  flags,
  input logic [DEPW-1:0]  nest_depth,
  input lvl_t             top_lvl,
  input lvl_t             req_lvl
);
  localparam logic [VECW-1:0] AUX_IDX = VECW'(AUX_SRC);
  localparam logic [DEPW-1:0] NEST_D  = DEPW'(NEST);

  logic flag_wr;
  assign flag_wr = reg_wr && (reg_addr == A_FLG_LO || reg_addr == A_FLG_HI);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !ack |=> irq_req && $stable(irq_vec));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && ack |=> !irq_req);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && ack && irq_vec != AUX_IDX && !src_set[irq_vec] && !flag_wr
    |=> !flags[$past(irq_vec)]);

  p_keep_aux_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && ack && irq_vec == AUX_IDX && !flag_wr |=> flags[AUX_SRC]);

  p_nest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (nest_depth == '0 || req_lvl > top_lvl));

  p_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= NEST_D);

  p_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    src_set[0] |=> flags[0]);

  p_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_LVL_LO |-> !reg_rdata[7]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .src_set(src_set), .ack(ack),
  .irq_req(irq_req), .irq_vec(irq_vec), .flags(flags),
  .nest_depth(nest_depth), .top_lvl(top_lvl), .req_lvl(req_lvl)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [11:0] src_set = '0;
  logic        ack = 1'b0, reti = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_vec;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .src_set, .ack, .reti, .irq_req, .irq_vec
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [11:0] m_en, m_flg;
  logic [5:0]  m_lo, m_hi;
  logic        m_gen, m_wd, m_req;
  int          m_vec, m_lvl;
  int          stk[$];

  function automatic int m_level(int s);
    return (m_hi[s/2] ? 2 : 0) + (m_lo[s/2] ? 1 : 0);
  endfunction

  function automatic bit m_elig(int s);
    bit e;
    e = m_flg[s] && m_en[s] && m_gen;
    if (s == 11) e = e && m_en[10];
    return e;
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_en[7:0];
      3'd1: return {m_gen, 3'b000, m_en[11:8]};
      3'd2: return m_flg[7:0];
      3'd3: return {4'h0, m_flg[11:8]};
      3'd4: return {1'b0, m_wd, m_lo};
      3'd5: return {2'b00, m_hi};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_flg = '0; m_lo = '0; m_hi = '0;
      m_gen = 0; m_wd = 0; m_req = 0; m_vec = 0; m_lvl = 0;
      stk.delete();
    end else begin
      bit wf, fwd, took;
      int wv, wl;
      wf = 0; wv = 0; wl = 0;
      for (int lv = 3; lv >= 0; lv--)
        for (int s = 0; s < 12; s++)
          if (!wf && m_elig(s) && m_level(s) == lv) begin
            wf = 1; wv = s; wl = lv;
          end
      fwd  = wf && (stk.size() == 0 || wl > stk[$]);
      took = ack && m_req;
      if (reti && stk.size() > 0) void'(stk.pop_back());
      if (took) stk.push_back(m_lvl);
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_en[7:0] = reg_wdata;
          3'd1: begin m_en[11:8] = reg_wdata[3:0]; m_gen = reg_wdata[7]; end
          3'd2: m_flg[7:0] = reg_wdata;
          3'd3: m_flg[11:8] = reg_wdata[3:0];
          3'd4: begin m_lo = reg_wdata[5:0]; m_wd = reg_wdata[6]; end
          3'd5: m_hi = reg_wdata[5:0];
          default: ;
        endcase
      end
      if (took && m_vec != 11) m_flg[m_vec] = 1'b0;
      m_flg = m_flg | src_set;
      if (m_req) begin
        if (ack) m_req = 0;
      end else if (fwd) begin
        m_req = 1; m_vec = wv; m_lvl = wl;
      end
    end
    #2;
    if (!done) begin
      chk(irq_req === m_req, "R7 model irq_req", irq_req, m_req);
      if (m_req) chk(irq_vec === 4'(m_vec), "R5 model irq_vec", irq_vec, m_vec);
      chk(reg_rdata === m_read(reg_addr), "R1 model rdata", reg_rdata, m_read(reg_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse(input logic [11:0] m);
    @(negedge clk); src_set = m;
    @(negedge clk); src_set = '0;
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic do_reti;
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_addr = a; #1;
    chk(reg_rdata === e, tag, reg_rdata, e);
  endtask

  task automatic req_chk(input bit r, input int v, input string tag);
    #1;
    chk(irq_req === r, tag, irq_req, r);
    if (r) chk(irq_vec === 4'(v), tag, irq_vec, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'h00, "R1 reset read");
    req_chk(0, 0, "R1 no request after reset");
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h8F);
    rd_chk(3'd1, 8'h8F, "R1 enable high readback");
    // R2 unused bits and watchdog bit
    wr(3'd4, 8'hFF); rd_chk(3'd4, 8'h7F, "R2 level-low unused bit");
    wr(3'd5, 8'hFF); rd_chk(3'd5, 8'h3F, "R2 level-high unused bits");
    wr(3'd4, 8'h40); wr(3'd5, 8'h00);
    rd_chk(3'd4, 8'h40, "R2 watchdog bit kept");
    // R6 tie within level 0, R7 hold
    pulse(12'h00C);
    idle(1); req_chk(1, 2, "R6 tie picks lower index with R2 watchdog bit set");
    idle(3); req_chk(1, 2, "R7 held until ack");
    do_ack; req_chk(0, 0, "R8 request drops on ack");
    rd_chk(3'd2, 8'h08, "R8 acked flag cleared");
    idle(3); req_chk(0, 0, "R10 equal level blocked while nested");
    do_reti; idle(1); req_chk(1, 3, "R10 presented after reti");
    do_ack; do_reti;
    // R5 / R3 group 5 at level 3
    wr(3'd4, 8'h60); wr(3'd5, 8'h20);
    pulse(12'h401);
    idle(1); req_chk(1, 10, "R5 highest level wins (R3 group5)");
    do_ack; idle(2); req_chk(0, 0, "R10 lower level blocked");
    do_reti; idle(1); req_chk(1, 0, "R10 lower level after reti");
    do_ack; do_reti;
    // R3 group 2 at level 2 from the high register only
    wr(3'd4, 8'h40); wr(3'd5, 8'h04);
    pulse(12'h022);
    idle(1); req_chk(1, 5, "R3 ext3 in group2 at level2");
    do_ack; do_reti;
    idle(1); req_chk(1, 1, "R3 serial1 follows");
    do_ack; do_reti;
    // R4 enable gating
    wr(3'd5, 8'h00);
    wr(3'd0, 8'hFE);
    pulse(12'h001);
    idle(2); req_chk(0, 0, "R4 source disabled");
    rd_chk(3'd2, 8'h01, "R4 flag still pending");
    wr(3'd1, 8'h0F); wr(3'd0, 8'hFF);
    idle(2); req_chk(0, 0, "R4 global disabled");
    wr(3'd1, 8'h8F);
    idle(1); req_chk(1, 0, "R4 enabled again");
    do_ack; do_reti;
    // R9 sub-source
    wr(3'd1, 8'h8B);
    pulse(12'h800);
    idle(2); req_chk(0, 0, "R9 host enable off blocks sub-source");
    wr(3'd1, 8'h8F);
    idle(1); req_chk(1, 11, "R9 sub-source presented");
    do_ack;
    rd_chk(3'd3, 8'h08, "R9 sub-source flag kept on ack");
    do_reti; idle(1); req_chk(1, 11, "R9 sub-source again");
    do_ack; wr(3'd3, 8'h00); do_reti;
    idle(2); req_chk(0, 0, "R9 software clear");
    rd_chk(3'd3, 8'h00, "R9 flag cleared by write");
    // R11 set wins over ack clear
    pulse(12'h010);
    idle(1); req_chk(1, 4, "R11 ext1 presented");
    @(negedge clk); ack = 1; src_set = 12'h010;
    @(negedge clk); ack = 0; src_set = '0;
    rd_chk(3'd2, 8'h10, "R11 set beats ack clear");
    do_reti; idle(1); req_chk(1, 4, "R11 re-request");
    do_ack; do_reti;
    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule